// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This purely combinational block sits beside the execute stage of a five-stage, in-order integer pipeline. Each cycle it compares the two source register numbers of the instruction entering execute against the destination register numbers of the two older instructions. Those older instructions sit in the execute/memory latch and in the memory/writeback latch. From that comparison it produces a mux select for ALU operand A and one for ALU operand B. Each select picks the register file value, the execute/memory result or the memory/writeback result.

It also drives a third select for the memory stage. When a store sits in the execute/memory latch and the instruction just ahead of it is a load writing the store's data register, the loaded value is steered from the memory/writeback latch into the store's memory data input. The store then needs no stall.

A dependence three instructions apart gets no bypass. The register file writes in the first half of a cycle and reads in the second half, so the reader already sees the new value. Register 0 is hard-wired to zero and is never a bypass source. In an instruction word the sources sit at bits 25:21 and 20:16. An R-format destination sits at bits 15:11 and an I-format destination at bits 20:16. The surrounding decode logic extracts these fields, and the block receives the register numbers.

Top module: `fwd_unit`

## Requirements
- R1: When neither older instruction is a live writer of a source register, the select for that operand is 2'b00 (register file). This covers a producer three or more instructions older.
- R2: When the execute/memory latch writes a non-zero register equal to a source, and that instruction is not a load, the operand select is 2'b10.
- R3: When the memory/writeback latch writes a non-zero register equal to a source, the operand select is 2'b01 unless R2 applies. The producer may be an ALU instruction or a load.
- R4: When both latches qualify for the same source, the execute/memory (younger) value wins and the select is 2'b10.
- R5: A destination of register 0 never causes forwarding, on any select.
- R6: A latch whose register-write enable is low never causes forwarding, on any select.
- R7: A load held in the execute/memory latch is never forwarded to an ALU operand (its data is not yet available). Selection then falls back to R3 or R1.
- R8: The store-data select is 2'b01 exactly when the execute/memory instruction is a store, the memory/writeback instruction is a load with write enable high, and its non-zero destination equals the store's data register. Otherwise the store-data select is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs | input | REG_W | First source register of the instruction in execute |
| idex_rt | input | REG_W | Second source register of the instruction in execute |
| exm_dst | input | REG_W | Destination register in the execute/memory latch |
| exm_wen | input | 1 | Register-write enable in the execute/memory latch |
| exm_load | input | 1 | Execute/memory instruction is a load |
| exm_store | input | 1 | Execute/memory instruction is a store |
| exm_rt | input | REG_W | Store data register of the execute/memory instruction |
| mwb_dst | input | REG_W | Destination register in the memory/writeback latch |
| mwb_wen | input | 1 | Register-write enable in the memory/writeback latch |
| mwb_load | input | 1 | Memory/writeback instruction is a load |
| sel_a | output | 2 | ALU operand A select (00 file, 10 ex/mem, 01 mem/wb) |
| sel_b | output | 2 | ALU operand B select (same encoding) |
| sel_st | output | 2 | Store data select (00 normal path, 01 mem/wb load data) |

## Verification
The assertions assume the pipeline control sets the load and store flags for the execute/memory latch exclusively, and never marks an instruction both ways. They also assume the write enable of a store is low. The bench sweeps every combination of small register numbers, enables and flags, including ones the pipeline never produces, because the selection rules stay defined there. Only the store-flag combinations are kept apart: the loads and stores are driven so that at most one flag is raised per latch.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;

  // Younger latch first, then older latch, then register file.
  function automatic fwd_sel_e pick_sel(input logic ex_hit, input logic mw_hit);
    if (ex_hit)      return SEL_EXM;
    else if (mw_hit) return SEL_MWB;
    else             return SEL_RF;
  endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  input  logic             allow,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic live_dst;
  assign live_dst = wen && (dst != ZERO_REG);
  assign hit      = live_dst && allow && (dst == src);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic       ex_hit,
  input  logic       mw_hit,
  output logic [1:0] sel
);
  fwd_sel_e sel_e;
  always_comb sel_e = pick_sel(ex_hit, mw_hit);
  assign sel = sel_e;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idex_rs,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_wen,
  input  logic             exm_load,
  input  logic             exm_store,
  input  logic [REG_W-1:0] exm_rt,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic             mwb_wen,
  input  logic             mwb_load,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [1:0]       sel_st
);
  localparam int N_OPS = 2;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] op_src [N_OPS];
  logic [1:0]       op_sel [N_OPS];
  logic             ex_hit [N_OPS];
  logic             mw_hit [N_OPS];
  logic             ex_allow;
  logic             st_allow;
  logic             st_hit;

  assign op_src[0] = idex_rs;
  assign op_src[1] = idex_rt;
  assign ex_allow  = !exm_load;
  assign st_allow  = exm_store && mwb_load;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_match #(.REG_W(REG_W)) u_ex (
      .src(op_src[g]), .dst(exm_dst), .wen(exm_wen),
      .allow(ex_allow), .hit(ex_hit[g]));
    fwd_match #(.REG_W(REG_W)) u_mw (
      .src(op_src[g]), .dst(mwb_dst), .wen(mwb_wen),
      .allow(1'b1), .hit(mw_hit[g]));
    fwd_pick u_pick (
      .ex_hit(ex_hit[g]), .mw_hit(mw_hit[g]), .sel(op_sel[g]));
  end

  fwd_match #(.REG_W(REG_W)) u_st (
    .src(exm_rt), .dst(mwb_dst), .wen(mwb_wen),
    .allow(st_allow), .hit(st_hit));

  assign sel_a  = op_sel[0];
  assign sel_b  = op_sel[1];
  assign sel_st = st_hit ? SEL_MWB : SEL_RF;

  always_comb begin
    AST_A_EXM_LIVE: assert (sel_a != SEL_EXM || (exm_wen && exm_dst == idex_rs)); // R2
    AST_B_EXM_LIVE: assert (sel_b != SEL_EXM || (exm_wen && exm_dst == idex_rt)); // R2
    AST_A_MWB_LIVE: assert (sel_a != SEL_MWB || (mwb_wen && mwb_dst == idex_rs)); // R3
    AST_A_LEGAL:    assert (sel_a != 2'b11 && sel_b != 2'b11); // R4
    AST_ZERO_SRC:   assert (idex_rs != ZERO_REG || sel_a == SEL_RF); // R5
    AST_NO_WEN:     assert ((exm_wen || mwb_wen) || (sel_a == SEL_RF && sel_b == SEL_RF)); // R6
    AST_NO_LOAD_EX: assert (!exm_load || (sel_a != SEL_EXM && sel_b != SEL_EXM)); // R7
    AST_ST_LOAD:    assert (sel_st == SEL_RF || (mwb_load && exm_store && mwb_dst == exm_rt)); // R8
  end
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [RW-1:0] idex_rs, idex_rt, exm_dst, exm_rt, mwb_dst;
  logic exm_wen, exm_load, exm_store, mwb_wen, mwb_load;
  logic [1:0] sel_a, sel_b, sel_st;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  fwd_unit #(.REG_W(RW)) u_dut (
    .idex_rs(idex_rs), .idex_rt(idex_rt), .exm_dst(exm_dst), .exm_wen(exm_wen),
    .exm_load(exm_load), .exm_store(exm_store), .exm_rt(exm_rt),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .mwb_load(mwb_load),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st));

  // Expected operand select, built from the requirement text.
  function automatic logic [1:0] want_op(input logic [RW-1:0] s);
    logic young, old;
    young = (s != 0) && (s == exm_dst) && exm_wen && !exm_load;
    old   = (s != 0) && (s == mwb_dst) && mwb_wen;
    if (young) return 2'b10;
    if (old)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_op(input logic [RW-1:0] s, input logic [1:0] e);
    if (e == 2'b10 && s == mwb_dst && mwb_wen) return "R4";
    if (e == 2'b10) return "R2";
    if (s == exm_dst && exm_load && exm_wen && s != 0) return "R7";
    if (e == 2'b01) return "R3";
    if (s == 0 && (s == exm_dst || s == mwb_dst)) return "R5";
    if (s == exm_dst || s == mwb_dst) return "R6";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s rs=%0d rt=%0d exd=%0d exw=%0b exl=%0b exs=%0b exrt=%0d mwd=%0d mww=%0b mwl=%0b got=%b exp=%b",
               tag, idex_rs, idex_rt, exm_dst, exm_wen, exm_load, exm_store, exm_rt,
               mwb_dst, mwb_wen, mwb_load, got, exp);
    end
  endtask

  initial begin
    idex_rs = '0; idex_rt = '0; exm_dst = '0; exm_rt = '0; mwb_dst = '0;
    exm_wen = 0; exm_load = 0; exm_store = 0; mwb_wen = 0; mwb_load = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", sel_a, 2'b00);
    chk("R1", sel_b, 2'b00);
    chk("R8", sel_st, 2'b00);
    for (int v = 0; v < 32768; v++) begin
      @(posedge clk);
      idex_rs   = RW'(v[1:0]);
      idex_rt   = RW'(v[3:2]);
      exm_dst   = RW'(v[5:4]);
      mwb_dst   = RW'(v[7:6]);
      exm_wen   = v[8];
      mwb_wen   = v[9];
      exm_load  = v[10] && !v[12];
      exm_store = v[12];
      mwb_load  = v[11];
      exm_rt    = RW'(v[14:13]);
      @(negedge clk);
      begin
        logic [1:0] ea, eb, es;
        ea = want_op(idex_rs);
        eb = want_op(idex_rt);
        es = (exm_store && mwb_load && mwb_wen && mwb_dst != 0 && mwb_dst == exm_rt)
             ? 2'b01 : 2'b00;
        chk(tag_op(idex_rs, ea), sel_a, ea);
        chk(tag_op(idex_rt, eb), sel_b, eb);
        chk("R8", sel_st, es);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired got=running exp=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule